// File: doc/BRIEF.md
# ATA Bus Software Reset Sequencer

This block performs a software reset of both devices on one parallel ATA bus and reports when the bus can be used again. A single-cycle `start` pulse launches the sequence. The block then sets the soft-reset bit in the bus's device control register and keeps it set for a minimum number of clock cycles. After that it writes the register back to all zeros. Next it polls the alternate status register until the selected device reports not-busy and ready. The sequence ends with a one-cycle `done` pulse, or with a one-cycle `timeoutErr` pulse if the device never becomes ready within a cycle budget.

The block reaches the control block through a simple request/acknowledge master port. `busWe` high means a write to the device control register, and `busWe` low means a read of alternate status. A request stays asserted, with its data unchanged, until the control block answers with `busAck`. On a read, `busRData` is valid in the acknowledge cycle. The task-file registers are never touched. Because a software reset always leaves the master device selected, the block raises `selMaster` once the reset has been applied.

All times are given in clock cycles through parameters: the reset pulse width (`PULSE_CYCLES`), the number of status reads thrown away as settling time (`SETTLE_READS`), and the ready budget (`TIMEOUT_CYCLES`).

Top module: `ata_srst_seq`

## Requirements
- R1: After `start` in the idle state, the first bus operation is a write of 0x04, with bit 2 (soft reset) set and all other bits clear.
- R2: Counted from the acknowledge of the 0x04 write, at least `PULSE_CYCLES` cycles pass before the releasing write is requested.
- R3: The releasing write carries 0x00. No write ever sets bit 1 (interrupt disable), bit 7 (high-order byte readback) or any reserved bit, so the only write values are 0x04 and 0x00.
- R4: The first `SETTLE_READS` status reads after the release are discarded whatever their value, so `done` never follows fewer than `SETTLE_READS`+1 reads.
- R5: After the discarded reads, a status value ends the sequence only when bits 7:6 equal 01 (busy clear, ready set). Bits 5:0 are ignored. Values such as 0x80, 0xC0, 0x00 and 0xFF keep polling.
- R6: `done` is a pulse exactly one cycle long, issued once per completed sequence.
- R7: If no ready status is seen by the time `TIMEOUT_CYCLES` cycles have passed since the release was acknowledged, `timeoutErr` pulses for one cycle, `done` stays low, and no further bus operation is made.
- R8: A `start` pulse while a sequence is running is ignored. It neither restarts the sequence nor queues another one.
- R9: `selMaster` rises when the soft-reset write is acknowledged and never falls afterwards, except on `rstN`.
- R10: A bus request holds `busReq`, `busWe` and `busWData` steady until `busAck` is seen.
- R11: After `rstN`, `busReq`, `done`, `timeoutErr` and `selMaster` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches a reset sequence when idle |
| busReq | output | 1 | Register access request, held until acknowledged |
| busWe | output | 1 | 1: write device control, 0: read alternate status |
| busWData | output | 8 | Device control write value |
| busAck | input | 1 | Access completed this cycle |
| busRData | input | 8 | Alternate status value, valid with `busAck` on reads |
| done | output | 1 | One-cycle pulse: bus ready after reset |
| timeoutErr | output | 1 | One-cycle pulse: ready not reached within budget |
| selMaster | output | 1 | Master device is known to be selected |

## Verification
The properties in the checker are evaluated on every cycle. They cover the following: only the two legal control values are ever written; the soft-reset bit is held for the minimum pulse count before release; every `done` follows more than the settling number of reads and a last status with bits 7:6 equal to 01; requests stay steady until acknowledged; `done` and `timeoutErr` are single-cycle and never coincide; and `selMaster` never drops. Some behaviours can only be shown by the bench scenarios, because they depend on scripted status sequences and counts over a whole run. These are: exactly how many reads a given sequence takes, that busy, not-ready and floating-bus values keep the poll going, where the timeout lands relative to the budget, that the bus stays silent afterwards, and that extra `start` pulses produce no second reset.

// File: rtl/ata_srst_pkg.sv
package ata_srst_pkg;

  // Device control register values
  localparam logic [7:0] DEVCTL_SRST    = 8'h04;
  localparam logic [7:0] DEVCTL_RELEASE = 8'h00;

  // Alternate status: busy (bit 7) clear and ready (bit 6) set
  localparam logic [7:0] STATUS_MASK  = 8'hC0;
  localparam logic [7:0] STATUS_READY = 8'h40;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ASSERT,
    S_HOLD,
    S_RELEASE,
    S_POLL,
    S_EVAL,
    S_DONE,
    S_TIMEOUT
  } seqState_t;

  typedef struct packed {
    logic loadPulse;
    logic loadTimer;
    logic clearDiscard;
    logic bumpDiscard;
    logic captureStatus;
    logic markMaster;
    logic driveSet;
  } dpCtl_t;

endpackage

// File: rtl/ata_srst_dpath.sv
module ata_srst_dpath
  import ata_srst_pkg::*;
#(
  parameter int PULSE_CYCLES   = 625,
  parameter int SETTLE_READS   = 4,
  parameter int TIMEOUT_CYCLES = 125000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic [7:0] busRData,
  output logic [7:0] busWData,
  output logic       pulseDone,
  output logic       timerExpired,
  output logic       discardsDone,
  output logic       statusReady,
  output logic       selMaster
);

  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int DW = $clog2(SETTLE_READS + 1);
  localparam logic [PW-1:0] PULSE_LOAD  = PW'(PULSE_CYCLES - 1);
  localparam logic [TW-1:0] TIMER_LIMIT = TW'(TIMEOUT_CYCLES);
  localparam logic [DW-1:0] DISCARD_MAX = DW'(SETTLE_READS);

  logic [PW-1:0] pulseCnt;
  logic [TW-1:0] timerCnt;
  logic [DW-1:0] discardCnt;
  logic [7:0]    statusReg;
  logic          masterReg;

  // Reset pulse width counter, counts down to zero
  always_ff @(posedge clk) begin
    if (!rstN)                pulseCnt <= '0;
    else if (ctl.loadPulse)   pulseCnt <= PULSE_LOAD;
    else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
  end

  // Ready budget timer, saturates at the limit
  always_ff @(posedge clk) begin
    if (!rstN)                      timerCnt <= '0;
    else if (ctl.loadTimer)         timerCnt <= '0;
    else if (timerCnt < TIMER_LIMIT) timerCnt <= timerCnt + 1'b1;
  end

  // Settling read counter
  always_ff @(posedge clk) begin
    if (!rstN)                                    discardCnt <= '0;
    else if (ctl.clearDiscard)                    discardCnt <= '0;
    else if (ctl.bumpDiscard && discardCnt != DISCARD_MAX)
                                                  discardCnt <= discardCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  statusReg <= '0;
    else if (ctl.captureStatus) statusReg <= busRData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               masterReg <= 1'b0;
    else if (ctl.markMaster) masterReg <= 1'b1;
  end

  assign busWData     = ctl.driveSet ? DEVCTL_SRST : DEVCTL_RELEASE;
  assign pulseDone    = (pulseCnt == '0);
  assign timerExpired = (timerCnt >= TIMER_LIMIT);
  assign discardsDone = (discardCnt == DISCARD_MAX);
  assign statusReady  = ((statusReg & STATUS_MASK) == STATUS_READY);
  assign selMaster    = masterReg;

endmodule

// File: rtl/ata_srst_ctrl.sv
module ata_srst_ctrl
  import ata_srst_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   busAck,
  input  logic   pulseDone,
  input  logic   timerExpired,
  input  logic   discardsDone,
  input  logic   statusReady,
  output logic   busReq,
  output logic   busWe,
  output logic   done,
  output logic   timeoutErr,
  output dpCtl_t ctl
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState  = state;
    ctl        = '0;
    busReq     = 1'b0;
    busWe      = 1'b0;
    done       = 1'b0;
    timeoutErr = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) nextState = S_ASSERT;
      end
      S_ASSERT: begin
        busReq       = 1'b1;
        busWe        = 1'b1;
        ctl.driveSet = 1'b1;
        if (busAck) begin
          ctl.loadPulse  = 1'b1;
          ctl.markMaster = 1'b1;
          nextState      = S_HOLD;
        end
      end
      S_HOLD: begin
        if (pulseDone) nextState = S_RELEASE;
      end
      S_RELEASE: begin
        busReq = 1'b1;
        busWe  = 1'b1;
        if (busAck) begin
          ctl.loadTimer    = 1'b1;
          ctl.clearDiscard = 1'b1;
          nextState        = S_POLL;
        end
      end
      S_POLL: begin
        busReq = 1'b1;
        if (busAck) begin
          ctl.captureStatus = 1'b1;
          nextState         = S_EVAL;
        end
      end
      S_EVAL: begin
        if (!discardsDone) begin
          ctl.bumpDiscard = 1'b1;
          nextState       = timerExpired ? S_TIMEOUT : S_POLL;
        end else if (statusReady) begin
          nextState = S_DONE;
        end else begin
          nextState = timerExpired ? S_TIMEOUT : S_POLL;
        end
      end
      S_DONE: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      S_TIMEOUT: begin
        timeoutErr = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/ata_srst_seq.sv
module ata_srst_seq
  import ata_srst_pkg::*;
#(
  parameter int PULSE_CYCLES   = 625,
  parameter int SETTLE_READS   = 4,
  parameter int TIMEOUT_CYCLES = 125000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic       busReq,
  output logic       busWe,
  output logic [7:0] busWData,
  input  logic       busAck,
  input  logic [7:0] busRData,
  output logic       done,
  output logic       timeoutErr,
  output logic       selMaster
);

  dpCtl_t ctl;
  logic   pulseDone;
  logic   timerExpired;
  logic   discardsDone;
  logic   statusReady;

  ata_srst_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .busAck       (busAck),
    .pulseDone    (pulseDone),
    .timerExpired (timerExpired),
    .discardsDone (discardsDone),
    .statusReady  (statusReady),
    .busReq       (busReq),
    .busWe        (busWe),
    .done         (done),
    .timeoutErr   (timeoutErr),
    .ctl          (ctl)
  );

  ata_srst_dpath #(
    .PULSE_CYCLES   (PULSE_CYCLES),
    .SETTLE_READS   (SETTLE_READS),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) uDpath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .busRData     (busRData),
    .busWData     (busWData),
    .pulseDone    (pulseDone),
    .timerExpired (timerExpired),
    .discardsDone (discardsDone),
    .statusReady  (statusReady),
    .selMaster    (selMaster)
  );

endmodule

// File: rtl/ata_srst_seq_chk.sv
module ata_srst_seq_chk #(
  parameter int PULSE_CYCLES   = 625,
  parameter int SETTLE_READS   = 4,
  parameter int TIMEOUT_CYCLES = 125000000
) (
  input logic       clk,
  input logic       rstN,
  input logic       busReq,
  input logic       busWe,
  input logic [7:0] busWData,
  input logic       busAck,
  input logic [7:0] busRData,
  input logic       done,
  input logic       timeoutErr,
  input logic       selMaster
);

  localparam int HW = $clog2(PULSE_CYCLES + 2);
  localparam int RW = $clog2(SETTLE_READS + 2);
  localparam logic [HW-1:0] HOLD_MIN = HW'(PULSE_CYCLES);
  localparam logic [RW-1:0] RD_SAT   = RW'(SETTLE_READS + 1);

  logic          srstOn;
  logic [HW-1:0] holdCnt;
  logic [RW-1:0] readsSince;
  logic [7:0]    lastStatus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srstOn <= 1'b0;
      holdCnt <= '0;
    end else if (busReq && busWe && busAck && busWData == 8'h04) begin
      srstOn  <= 1'b1;
      holdCnt <= '0;
    end else if (busReq && busWe && busAck && busWData == 8'h00) begin
      srstOn <= 1'b0;
    end else if (srstOn && holdCnt < HOLD_MIN) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readsSince <= '0;
      lastStatus <= '0;
    end else if (busReq && busWe && busAck && busWData == 8'h00) begin
      readsSince <= '0;
    end else if (busReq && !busWe && busAck) begin
      lastStatus <= busRData;
      if (readsSince < RD_SAT) readsSince <= readsSince + 1'b1;
    end
  end

  // R1 and R3: only the set and release values are ever written
  assert_legal_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe) |-> (busWData == 8'h04 || busWData == 8'h00));

  assert_hold_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && busWData == 8'h00 && srstOn) |-> (holdCnt >= HOLD_MIN));

  assert_settle_reads_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (readsSince == RD_SAT));

  assert_ready_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (lastStatus[7:6] == 2'b01));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_timeout_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> (!timeoutErr && !busReq));

  assert_end_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeoutErr));

  assert_master_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    selMaster |=> selMaster);

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busWe) && $stable(busWData)));

endmodule

bind ata_srst_seq ata_srst_seq_chk #(
  .PULSE_CYCLES   (PULSE_CYCLES),
  .SETTLE_READS   (SETTLE_READS),
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busReq     (busReq),
  .busWe      (busWe),
  .busWData   (busWData),
  .busAck     (busAck),
  .busRData   (busRData),
  .done       (done),
  .timeoutErr (timeoutErr),
  .selMaster  (selMaster)
);

// File: tb/sim_ata_srst_seq.sv
`timescale 1ns/1ps
module sim_ata_srst_seq;

  localparam int PULSE   = 20;
  localparam int SETTLE  = 4;
  localparam int TIMEOUT = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       busReq, busWe, busAck = 1'b0;
  logic [7:0] busWData, busRData = 8'h00;
  logic       done, timeoutErr, selMaster;

  always #4 clk = ~clk;

  ata_srst_seq #(
    .PULSE_CYCLES   (PULSE),
    .SETTLE_READS   (SETTLE),
    .TIMEOUT_CYCLES (TIMEOUT)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .busReq(busReq), .busWe(busWe), .busWData(busWData),
    .busAck(busAck), .busRData(busRData),
    .done(done), .timeoutErr(timeoutErr), .selMaster(selMaster)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Responder and monitor state
  logic [7:0] statusSeq [16];
  int   seqLen = 1;
  int   ackDelay = 0;
  int   waitCnt = 0;
  int   wrCount = 0;
  int   rdCount = 0;
  logic [7:0] wrVal [4];
  int   setAckCyc = 0, relAckCyc = 0, relReqCyc = 0;
  bit   relReqSeen = 0;
  bit   unstable = 0;
  logic heldWe;
  logic [7:0] heldData;
  bit   holding = 0;
  int   doneCnt = 0, toutCnt = 0, toutCyc = 0;
  bit   doneWide = 0, toutWide = 0, prevDone = 0, prevTout = 0;

  function automatic logic [7:0] seqVal(int idx);
    return (idx < seqLen) ? statusSeq[idx] : statusSeq[seqLen-1];
  endfunction

  always @(negedge clk) begin
    if (done) begin doneCnt++; if (prevDone) doneWide = 1; end
    if (timeoutErr) begin toutCnt++; toutCyc = cyc; if (prevTout) toutWide = 1; end
    prevDone = done;
    prevTout = timeoutErr;
    if (busReq && busWe && busWData == 8'h00 && !relReqSeen) begin
      relReqSeen = 1; relReqCyc = cyc;
    end
    if (busAck) begin
      busAck = 1'b0;
      holding = 0;
    end else if (busReq) begin
      if (holding && (busWe !== heldWe || busWData !== heldData)) unstable = 1;
      holding = 1; heldWe = busWe; heldData = busWData;
      if (waitCnt < ackDelay) waitCnt++;
      else begin
        waitCnt = 0;
        busAck = 1'b1;
        if (busWe) begin
          if (wrCount < 4) wrVal[wrCount] = busWData;
          if (busWData == 8'h04) setAckCyc = cyc;
          if (busWData == 8'h00) relAckCyc = cyc;
          wrCount++;
        end else begin
          busRData = seqVal(rdCount);
          rdCount++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    wrCount = 0; rdCount = 0; relReqSeen = 0; unstable = 0;
    doneCnt = 0; toutCnt = 0; doneWide = 0; toutWide = 0;
    for (int i = 0; i < 4; i++) wrVal[i] = 8'hEE;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitEnd();
    int n = 0;
    while (doneCnt == 0 && toutCnt == 0 && n < 4000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(busReq == 1'b0, "R11 busReq", busReq, 0);
    check(done == 1'b0 && timeoutErr == 1'b0, "R11 done/timeoutErr", done | timeoutErr, 0);
    check(selMaster == 1'b0, "R11 selMaster", selMaster, 0);
  endtask

  task automatic testBasic();
    clearLog();
    statusSeq[0] = 8'h40; seqLen = 1; ackDelay = 0;
    pulseStart();
    waitEnd();
    check(wrVal[0] == 8'h04, "R1 set value", wrVal[0], 4);
    check(wrVal[1] == 8'h00, "R3 release value", wrVal[1], 0);
    check(wrCount == 2, "R3 write count", wrCount, 2);
    check(relReqCyc - setAckCyc >= PULSE && relReqCyc - setAckCyc <= PULSE + 2,
          "R2 hold gap", relReqCyc - setAckCyc, PULSE + 1);
    check(rdCount == SETTLE + 1, "R4 reads with early ready", rdCount, SETTLE + 1);
    check(doneCnt == 1 && !doneWide, "R6 single done pulse", doneCnt, 1);
    check(toutCnt == 0, "R7 no timeout", toutCnt, 0);
    check(selMaster == 1'b1, "R9 master selected", selMaster, 1);
  endtask

  task automatic testBusyPoll();
    clearLog();
    statusSeq[0] = 8'h40; statusSeq[1] = 8'h40; statusSeq[2] = 8'h40; statusSeq[3] = 8'h40;
    statusSeq[4] = 8'h80; statusSeq[5] = 8'hC0; statusSeq[6] = 8'h00; statusSeq[7] = 8'hFF;
    statusSeq[8] = 8'h49; seqLen = 9; ackDelay = 2;
    pulseStart();
    waitEnd();
    check(rdCount == 9, "R5 polls through busy/not-ready/float", rdCount, 9);
    check(doneCnt == 1, "R5 done on 01 with low bits set", doneCnt, 1);
    check(unstable == 0, "R10 request stable while waiting", unstable, 0);
    check(wrVal[0] == 8'h04 && wrVal[1] == 8'h00, "R10 write data under delay", wrVal[1], 0);
  endtask

  task automatic testTimeout();
    int opsAfter;
    clearLog();
    statusSeq[0] = 8'h80; seqLen = 1; ackDelay = 1;
    pulseStart();
    waitEnd();
    check(toutCnt == 1 && !toutWide, "R7 single timeout pulse", toutCnt, 1);
    check(doneCnt == 0, "R7 no done on timeout", doneCnt, 0);
    check(toutCyc - relAckCyc >= TIMEOUT && toutCyc - relAckCyc <= TIMEOUT + 8,
          "R7 timeout position", toutCyc - relAckCyc, TIMEOUT);
    opsAfter = wrCount + rdCount;
    repeat (30) @(negedge clk);
    check(wrCount + rdCount == opsAfter, "R7 bus silent after timeout", wrCount + rdCount, opsAfter);
  endtask

  task automatic testStartIgnored();
    clearLog();
    statusSeq[0] = 8'h40; statusSeq[1] = 8'h40; statusSeq[2] = 8'h40; statusSeq[3] = 8'h40;
    statusSeq[4] = 8'hC0; statusSeq[5] = 8'hC0; statusSeq[6] = 8'h40; seqLen = 7; ackDelay = 1;
    pulseStart();
    repeat (6) @(negedge clk);
    pulseStart();
    while (rdCount < 2) @(negedge clk);
    pulseStart();
    waitEnd();
    repeat (40) @(negedge clk);
    check(wrCount == 2, "R8 no second reset", wrCount, 2);
    check(doneCnt == 1, "R8 one done", doneCnt, 1);
    check(rdCount == 7, "R8 read count unaffected", rdCount, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testBusyPoll();
    testTimeout();
    testStartIgnored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule